// File: doc/BRIEF.md
# Banked Hypervisor Control Register File

This block holds the per-CPU state that a hypervisor programs to inject virtual interrupts into up to eight virtual CPUs. Each CPU bank has a control word, a packed virtual machine control word and a set of list registers, one per interrupt slot. Several read-only words are derived on every access from the list registers: which slots are empty, which slots have finished and asked for an end-of-interrupt notification, and a maintenance status byte.

Accesses arrive on a simple 32-bit register bus with a one-cycle registered response. An offset below 0x200 goes to the bank of the requesting CPU. A higher offset names a bank explicitly: bits above bit 8 give the bank number and the low 9 bits give the register. Illegal accesses raise an error flag and leave all stored state untouched. The list register contents, the per-bank enable bit and the maintenance status byte are also exported for the guest-facing side and the maintenance interrupt logic.

Top module: `hvctl_regfile`

## Requirements
- R1: During and right after a synchronous reset, every stored word is zero, `rsp_valid` is low, and `hen_o`, `maint_o` and `lr_o` are all zero.
- R2: Every request cycle is answered by `rsp_valid` high in the next cycle. A read returns its data in that cycle, and a write or an error response returns zero data.
- R3: When `req_addr` is below 0x200, the access targets the bank selected by `req_cpu`.
- R4: When any bit of `req_addr` above bit 8 is set, the bank is `req_addr >> 9` and the register is `req_addr[8:0]`. The same storage is reached as through the requester path.
- R5: An explicit bank number of NUM_CPU or more (8 to 15 by default) gives an error response and changes no state.
- R6: The type word at 0x004 reads 0x44000000 ORed with NUM_LR-1.
- R7: The VM control word at 0x008 holds the priority mask in [31:27], binary point in [23:21], aliased binary point in [20:18], EOI mode in bit 9, and bits 4, 3, 2, 1, 0 as common binary point, FIQ enable, acknowledge control, group-1 enable and group-0 enable. A write stores these fields and every other bit reads zero.
- R8: List register i sits at 0x100+4*i and is fully readable and writable. Its state field is [29:28], where 0 is invalid and 1 is pending, and its end-of-interrupt request flag is bit 19.
- R9: At 0x030, bit i is set when list register i has state 0. The word at 0x034 covers list registers 32 and above.
- R10: The end-of-interrupt status is 64 bits, read at 0x020 (low) and 0x024 (high). Bit i is set when list register i has state 0 and bit 19 set.
- R11: The active-priority word at 0x0F0 reads zero. A write to it is accepted without error and changes nothing.
- R12: Any other offset, and any write to the read-only words at 0x004, 0x010, 0x020, 0x024, 0x030 and 0x034, gives `rsp_err` for one cycle with zero data and no state change.
- R13: The maintenance byte, read at 0x010 and exported on `maint_o`, is built from the control word h and the VM control word. Bit 7 is h[7] and not group-1 enable. Bit 6 is h[6] and group-1 enable. Bit 5 is h[5] and not group-0 enable. Bit 4 is h[4] and group-0 enable. Bit 3 is h[3] and no list register pending. Bit 2 is h[2] and h[31:27] nonzero. Bit 1 is h[1] and at most one list register non-invalid. Bit 0 is any end-of-interrupt status bit set.
- R14: The control word at 0x000 is a full 32-bit read/write word, and its bit 0 appears on `hen_o` for that bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 for write, 0 for read |
| req_cpu | input | $clog2(NUM_CPU) | CPU issuing the request |
| req_addr | input | AW | Byte offset inside the register window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Access was illegal |
| rsp_rdata | output | 32 | Read data |
| lr_o | output | NUM_CPU*NUM_LR*32 | All list registers, bank-major |
| hen_o | output | NUM_CPU | Bit 0 of each bank's control word |
| maint_o | output | NUM_CPU*8 | Maintenance byte per bank |

## Verification
Random reads and writes go to every legal register. Each one is routed either through the requester path or through an explicit bank slice, so a bench model that keeps one store per bank shows whether the two paths reach the same storage. List register writes use random words, so the state field takes all four values, and this separates the empty, end-of-interrupt and maintenance computations from each other. Directed cases cover the default values after reset, full-ones writes to the VM control word, writes to the active-priority word, bank numbers at and above the CPU count, misaligned and unmapped offsets, and writes to read-only words.

// File: rtl/vgh_pkg.sv
package vgh_pkg;

    localparam logic [31:0] TYPE_BASE = 32'h4400_0000;

    typedef enum logic [3:0] {
        RK_CTRL, RK_TYPE, RK_VMCR, RK_MISR, RK_EISR_LO, RK_EISR_HI,
        RK_ELSR_LO, RK_ELSR_HI, RK_APR, RK_LR, RK_BAD
    } reg_kind_e;

    typedef struct packed {
        logic [4:0] pmask;
        logic [2:0] bpt;
        logic [2:0] abpt;
        logic       eoim;
        logic       cbpt;
        logic       fiq;
        logic       ack;
        logic       grp1;
        logic       grp0;
    } vmcr_t;

    function automatic vmcr_t vmcr_unpack(input logic [31:0] w);
        vmcr_t v;
        v.pmask = w[31:27];
        v.bpt   = w[23:21];
        v.abpt  = w[20:18];
        v.eoim  = w[9];
        v.cbpt  = w[4];
        v.fiq   = w[3];
        v.ack   = w[2];
        v.grp1  = w[1];
        v.grp0  = w[0];
        return v;
    endfunction

    function automatic logic [31:0] vmcr_pack(input vmcr_t v);
        logic [31:0] w;
        w        = '0;
        w[31:27] = v.pmask;
        w[23:21] = v.bpt;
        w[20:18] = v.abpt;
        w[9]     = v.eoim;
        w[4:0]   = {v.cbpt, v.fiq, v.ack, v.grp1, v.grp0};
        return w;
    endfunction

    function automatic logic [1:0] lr_state(input logic [31:0] w);
        return w[29:28];
    endfunction

    function automatic logic lr_eoi_req(input logic [31:0] w);
        return w[19];
    endfunction

    function automatic logic is_read_only(input reg_kind_e k);
        return (k == RK_TYPE) || (k == RK_MISR) || (k == RK_EISR_LO) ||
               (k == RK_EISR_HI) || (k == RK_ELSR_LO) || (k == RK_ELSR_HI);
    endfunction

endpackage

// File: rtl/vgh_decode.sv
module vgh_decode
    import vgh_pkg::*;
#(
    parameter int NUM_CPU = 8,
    parameter int NUM_LR  = 4,
    parameter int AW      = 13,
    localparam int CW     = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int LIW    = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
    input  logic [AW-1:0]  addr,
    input  logic [CW-1:0]  req_cpu,
    output logic [CW-1:0]  cpu_sel,
    output reg_kind_e      kind,
    output logic [LIW-1:0] lr_idx,
    output logic           bad_bank
);
    localparam int SW = AW - 9;

    logic [SW-1:0] slice;
    logic [8:0]    reg_off;

    assign slice   = addr[AW-1:9];
    assign reg_off = addr[8:0];

    always_comb begin
        if (slice != '0) begin
            cpu_sel  = slice[CW-1:0];
            bad_bank = 32'(slice) >= NUM_CPU;
        end else begin
            cpu_sel  = req_cpu;
            bad_bank = 32'(req_cpu) >= NUM_CPU;
        end
    end

    always_comb begin
        lr_idx = reg_off[2 +: LIW];
        unique case (reg_off)
            9'h000:  kind = RK_CTRL;
            9'h004:  kind = RK_TYPE;
            9'h008:  kind = RK_VMCR;
            9'h010:  kind = RK_MISR;
            9'h020:  kind = RK_EISR_LO;
            9'h024:  kind = RK_EISR_HI;
            9'h030:  kind = RK_ELSR_LO;
            9'h034:  kind = RK_ELSR_HI;
            9'h0F0:  kind = RK_APR;
            default: begin
                if (reg_off[8] && reg_off[1:0] == 2'b00 &&
                    32'(reg_off[7:2]) < NUM_LR)
                    kind = RK_LR;
                else
                    kind = RK_BAD;
            end
        endcase
    end
endmodule

// File: rtl/vgh_bank.sv
module vgh_bank
    import vgh_pkg::*;
#(
    parameter int NUM_LR = 4,
    localparam int LIW   = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  reg_kind_e              kind,
    input  logic [LIW-1:0]         lr_idx,
    input  logic [31:0]            wdata,
    output logic [31:0]            rdata,
    output logic [NUM_LR*32-1:0]   lr_flat,
    output logic                   hen,
    output logic [7:0]             maint
);
    logic [31:0] hcr_q;
    vmcr_t       vmcr_q;
    logic [31:0] lr_q [NUM_LR];

    logic [63:0]       empty_w;
    logic [63:0]       eois_w;
    logic [NUM_LR-1:0] pend_w;
    logic [NUM_LR-1:0] used_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            hcr_q  <= '0;
            vmcr_q <= '0;
            for (int i = 0; i < NUM_LR; i++) lr_q[i] <= '0;
        end else if (wr_en) begin
            case (kind)
                RK_CTRL: hcr_q          <= wdata;
                RK_VMCR: vmcr_q         <= vmcr_unpack(wdata);
                RK_LR:   lr_q[lr_idx]   <= wdata;
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < NUM_LR; g++) begin : g_lr
        assign lr_flat[g*32 +: 32] = lr_q[g];
        assign pend_w[g]           = lr_state(lr_q[g]) == 2'b01;
        assign used_w[g]           = lr_state(lr_q[g]) != 2'b00;
    end

    always_comb begin
        empty_w = '0;
        eois_w  = '0;
        for (int i = 0; i < NUM_LR; i++) begin
            empty_w[i] = lr_state(lr_q[i]) == 2'b00;
            eois_w[i]  = empty_w[i] && lr_eoi_req(lr_q[i]);
        end
    end

    always_comb begin
        maint[7] = hcr_q[7] && !vmcr_q.grp1;
        maint[6] = hcr_q[6] &&  vmcr_q.grp1;
        maint[5] = hcr_q[5] && !vmcr_q.grp0;
        maint[4] = hcr_q[4] &&  vmcr_q.grp0;
        maint[3] = hcr_q[3] && (pend_w == '0);
        maint[2] = hcr_q[2] && (hcr_q[31:27] != 5'd0);
        maint[1] = hcr_q[1] && ($countones(used_w) <= 1);
        maint[0] = eois_w != '0;
    end

    assign hen = hcr_q[0];

    always_comb begin
        case (kind)
            RK_CTRL:    rdata = hcr_q;
            RK_TYPE:    rdata = TYPE_BASE | 32'(NUM_LR - 1);
            RK_VMCR:    rdata = vmcr_pack(vmcr_q);
            RK_MISR:    rdata = {24'd0, maint};
            RK_EISR_LO: rdata = eois_w[31:0];
            RK_EISR_HI: rdata = eois_w[63:32];
            RK_ELSR_LO: rdata = empty_w[31:0];
            RK_ELSR_HI: rdata = empty_w[63:32];
            RK_LR:      rdata = lr_q[lr_idx];
            default:    rdata = '0;
        endcase
    end

    // R10: a finished slot is always also an empty slot
    assert_eois_in_empty_R10: assert property (@(posedge clk) disable iff (rst)
        (eois_w & ~empty_w) == 64'd0);

    // R11: writing the active-priority word leaves every stored word alone
    assert_apr_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && kind == RK_APR) |=> ($stable(hcr_q) && $stable(vmcr_q) && $stable(lr_flat)));

    // R7: bits outside the VM control fields never read back as set
    assert_vmcr_mask_R7: assert property (@(posedge clk) disable iff (rst)
        (kind == RK_VMCR) |-> ((rdata & ~32'hF8FC_021F) == 32'd0));
endmodule

// File: rtl/hvctl_regfile.sv
module hvctl_regfile
    import vgh_pkg::*;
#(
    parameter int NUM_CPU = 8,
    parameter int NUM_LR  = 4,
    parameter int AW      = 13,
    localparam int CW     = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int LIW    = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid,
    input  logic                          req_write,
    input  logic [CW-1:0]                 req_cpu,
    input  logic [AW-1:0]                 req_addr,
    input  logic [31:0]                   req_wdata,
    output logic                          rsp_valid,
    output logic                          rsp_err,
    output logic [31:0]                   rsp_rdata,
    output logic [NUM_CPU*NUM_LR*32-1:0]  lr_o,
    output logic [NUM_CPU-1:0]            hen_o,
    output logic [NUM_CPU*8-1:0]          maint_o
);
    logic [CW-1:0]  cpu_sel;
    reg_kind_e      kind;
    logic [LIW-1:0] lr_idx;
    logic           bad_bank;
    logic           legal;
    logic [31:0]    bank_rd [NUM_CPU];

    vgh_decode #(.NUM_CPU(NUM_CPU), .NUM_LR(NUM_LR), .AW(AW)) u_dec (
        .addr    (req_addr),
        .req_cpu (req_cpu),
        .cpu_sel (cpu_sel),
        .kind    (kind),
        .lr_idx  (lr_idx),
        .bad_bank(bad_bank)
    );

    assign legal = !bad_bank && kind != RK_BAD && !(req_write && is_read_only(kind));

    for (genvar b = 0; b < NUM_CPU; b++) begin : g_bank
        logic wr_b;
        assign wr_b = req_valid && req_write && legal && (32'(cpu_sel) == b);

        vgh_bank #(.NUM_LR(NUM_LR)) u_bank (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (wr_b),
            .kind   (kind),
            .lr_idx (lr_idx),
            .wdata  (req_wdata),
            .rdata  (bank_rd[b]),
            .lr_flat(lr_o[b*NUM_LR*32 +: NUM_LR*32]),
            .hen    (hen_o[b]),
            .maint  (maint_o[b*8 +: 8])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && !legal;
            rsp_rdata <= (req_valid && !req_write && legal) ? bank_rd[cpu_sel] : '0;
        end
    end

    // R2: every request is answered in the following cycle
    assert_resp_next_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R12: an error is only ever part of a response and carries no data
    assert_err_framed_R12: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_valid && rsp_rdata == 32'd0));

    // R5: a bank number outside the CPU range is rejected
    assert_bad_bank_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && 32'(req_addr[AW-1:9]) >= NUM_CPU) |=> rsp_err);

    // R12: a rejected access leaves the exported state unchanged
    assert_err_no_change_R12: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !legal) |=> ($stable(lr_o) && $stable(hen_o)));
endmodule

// File: tb/sim_hvctl_regfile.sv
module sim_hvctl_regfile;
    localparam int NC = 8;
    localparam int NL = 4;

    logic               clk = 1'b0;
    logic               rst;
    logic               req_valid, req_write;
    logic [2:0]         req_cpu;
    logic [12:0]        req_addr;
    logic [31:0]        req_wdata;
    logic               rsp_valid, rsp_err;
    logic [31:0]        rsp_rdata;
    logic [NC*NL*32-1:0] lr_o;
    logic [NC-1:0]      hen_o;
    logic [NC*8-1:0]    maint_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [31:0] m_hcr  [NC];
    logic [31:0] m_vmcr [NC];
    logic [31:0] m_lr   [NC][NL];

    always #2 clk = ~clk;

    hvctl_regfile #(.NUM_CPU(NC), .NUM_LR(NL), .AW(13)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_cpu(req_cpu), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .lr_o(lr_o), .hen_o(hen_o), .maint_o(maint_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // -1 unmapped, 0 ctrl, 1 type, 2 vmcr, 3 maint, 4/5 eoi lo/hi, 6/7 empty lo/hi, 8 apr, 9+i list reg i
    function automatic int kcode(input int off);
        case (off)
            'h000: return 0;
            'h004: return 1;
            'h008: return 2;
            'h010: return 3;
            'h020: return 4;
            'h024: return 5;
            'h030: return 6;
            'h034: return 7;
            'h0F0: return 8;
            default: if (off >= 'h100 && off % 4 == 0 && (off - 'h100) / 4 < NL) return 9 + (off - 'h100) / 4;
        endcase
        return -1;
    endfunction

    function automatic string ktag(input int c);
        case (c)
            0: return "R14";
            1: return "R6";
            2: return "R7";
            3: return "R13";
            4, 5: return "R10";
            6, 7: return "R9";
            8: return "R11";
            default: return (c >= 9) ? "R8" : "R12";
        endcase
    endfunction

    function automatic logic [63:0] eois64(input int c);
        logic [63:0] r = '0;
        for (int i = 0; i < NL; i++) r[i] = (m_lr[c][i][29:28] == 2'd0) && m_lr[c][i][19];
        return r;
    endfunction

    function automatic logic [63:0] empty64(input int c);
        logic [63:0] r = '0;
        for (int i = 0; i < NL; i++) r[i] = m_lr[c][i][29:28] == 2'd0;
        return r;
    endfunction

    function automatic logic [7:0] mstat(input int c);
        logic [31:0] h = m_hcr[c];
        logic g0 = m_vmcr[c][0];
        logic g1 = m_vmcr[c][1];
        bit pend = 0;
        int used = 0;
        for (int i = 0; i < NL; i++) begin
            if (m_lr[c][i][29:28] == 2'd1) pend = 1;
            if (m_lr[c][i][29:28] != 2'd0) used++;
        end
        return {h[7] && !g1, h[6] && g1, h[5] && !g0, h[4] && g0, h[3] && !pend,
                h[2] && (h[31:27] != 0), h[1] && (used <= 1), eois64(c) != 0};
    endfunction

    function automatic logic [31:0] mread(input int c, input int k);
        case (k)
            0: return m_hcr[c];
            1: return 32'h4400_0000 | (NL - 1);
            2: return m_vmcr[c];
            3: return {24'd0, mstat(c)};
            4: return eois64(c)[31:0];
            5: return eois64(c)[63:32];
            6: return empty64(c)[31:0];
            7: return empty64(c)[63:32];
            8: return 32'd0;
            default: return (k >= 9) ? m_lr[c][k-9] : 32'd0;
        endcase
    endfunction

    task automatic op(input bit wr, input int rcpu, input int slice, input int off, input logic [31:0] d);
        int k = kcode(off);
        int tc = (slice != 0) ? slice : rcpu;
        bit badb = slice >= NC;
        bit ro = (k == 1) || (k >= 3 && k <= 7);
        bit err = badb || k < 0 || (wr && ro);
        logic [31:0] expd = (!wr && !err) ? mread(tc, k) : 32'd0;
        string ptag = (slice != 0) ? "R4" : "R3";
        logic [NC-1:0] hexp;
        req_valid = 1'b1;
        req_write = wr;
        req_cpu   = 3'(rcpu);
        req_addr  = 13'((slice << 9) | off);
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid === 1'b1, "R2 rsp_valid", 64'(rsp_valid), 64'd1);
        chk(rsp_err === err, badb ? "R5 rsp_err" : "R12 rsp_err", 64'(rsp_err), 64'(err));
        chk(rsp_rdata === expd, {ptag, " ", ktag(k), " rsp_rdata"}, 64'(rsp_rdata), 64'(expd));
        if (wr && !err) begin
            if (k == 0) m_hcr[tc] = d;
            else if (k == 2) m_vmcr[tc] = d & 32'hF8FC_021F;
            else if (k >= 9) m_lr[tc][k-9] = d;
        end
        if (!badb) chk(maint_o[tc*8 +: 8] === mstat(tc), "R13 maint_o", 64'(maint_o[tc*8 +: 8]), 64'(mstat(tc)));
        for (int c = 0; c < NC; c++) hexp[c] = m_hcr[c][0];
        chk(hen_o === hexp, "R14 hen_o", 64'(hen_o), 64'(hexp));
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int offs [14] = '{'h000, 'h004, 'h008, 'h010, 'h020, 'h024, 'h030, 'h034,
                         'h0F0, 'h100, 'h104, 'h108, 'h10C, 'h00C};
        void'($urandom(32'd2718));
        for (int c = 0; c < NC; c++) begin
            m_hcr[c] = '0;
            m_vmcr[c] = '0;
            for (int i = 0; i < NL; i++) m_lr[c][i] = '0;
        end
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0;
        req_cpu = '0; req_addr = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        chk(rsp_valid === 1'b0, "R1 rsp_valid", 64'(rsp_valid), 64'd0);
        chk(hen_o === '0, "R1 hen_o", 64'(hen_o), 64'd0);
        chk(maint_o === '0, "R1 maint_o", 64'(maint_o), 64'd0);
        chk(lr_o === '0, "R1 lr_o", 64'(lr_o[63:0]), 64'd0);
        rst = 1'b0;

        // R1: every readable word of bank 3 right after reset
        for (int j = 0; j < 9; j++) op(0, 3, 0, offs[j], 0);
        op(0, 3, 0, 'h104, 0);
        // R6 type word through both paths
        op(0, 0, 5, 'h004, 0);
        // R7 all-ones into VM control, read back through the other path
        op(1, 2, 0, 'h008, 32'hFFFF_FFFF);
        op(0, 0, 2, 'h008, 0);
        // R4 explicit write, R3 banked read of the same list register
        op(1, 0, 5, 'h108, 32'h0008_0123);
        op(0, 5, 0, 'h108, 0);
        op(0, 5, 0, 'h020, 0);
        op(0, 5, 0, 'h030, 0);
        // R5 bank numbers at and above the CPU count
        op(1, 1, 8, 'h000, 32'hFFFF_FFFF);
        op(0, 1, 15, 'h100, 0);
        op(0, 1, 1, 'h000, 0);
        // R11 active priority ignored
        op(1, 4, 0, 'h000, 32'h8000_00FF);
        op(1, 4, 0, 'h0F0, 32'hFFFF_FFFF);
        op(0, 4, 0, 'h0F0, 0);
        op(0, 4, 0, 'h000, 0);
        // R12 unmapped, misaligned, out-of-range list reg, read-only writes
        op(1, 6, 0, 'h00C, 32'h1);
        op(1, 6, 0, 'h102, 32'h1);
        op(0, 6, 0, 'h110, 0);
        op(1, 6, 0, 'h004, 32'h1);
        op(1, 6, 0, 'h030, 32'h1);
        op(0, 6, 0, 'h1FC, 0);

        for (int n = 0; n < 3000; n++) begin
            int rc = $urandom % NC;
            int tc = $urandom % NC;
            int sl = ($urandom % 2 == 0) ? 0 : tc;
            int r = $urandom % 20;
            int off;
            logic [31:0] d = $urandom;
            if (r < 14) off = offs[r];
            else if (r < 18) off = 'h100 + 4 * ($urandom % NL);
            else off = ($urandom % 128) * 4;
            if ($urandom % 40 == 0) sl = 8 + $urandom % 8;
            if (sl == 0 && $urandom % 2 == 0) rc = tc;
            op($urandom % 2 == 1, rc, sl, off, d);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule